// File: doc/BRIEF.md
# JTAG Master Shift Engine

This block is the pin-level engine of a JTAG host. It drives TCK, TMS and TDI toward a single target TAP controller and samples the TDO line that comes back. A local sequencer issues one command at a time. There are four commands: walk the TAP to Run-Test/Idle through Test-Logic-Reset, walk it from idle to Shift-IR, walk it from idle to Shift-DR, and shift between 1 and 32 data bits.

A shift command takes a data word, a bit count and three flags. The first flag selects the bit order. The second decides whether the last data bit also leaves the Shift state. The third decides whether the TAP goes on from Update to Run-Test/Idle. The bits captured from TDO are merged into the same word as it shifts, so the result comes back in the order the bits were sent.

Each command starts with a one-cycle `start` pulse. `busy` stays high while the command runs, and `done` pulses for one cycle when it ends. The TCK rate comes from the system clock. A static divide value sets the length of each TCK phase.

Top module: `jtag_shift_master`

## Requirements
- R1: After reset, tck, tms and tdi are all 1, busy and done are 0, and dataOut is 0.
- R2: Command code 0 issues six TCK periods. TMS is 1 for the first five and 0 for the sixth.
- R3: Command code 1 issues four TCK periods with TMS 1,1,0,0.
- R4: Command code 2 issues three TCK periods with TMS 1,0,0.
- R5: When command code 3 runs with msbFirst = 0, dataIn bit 0 goes out on the first data TCK, then bits 1, 2 and so on. The TDO bit of data period i lands in dataOut bit i. dataIn bits at or above bitCount are ignored, and dataOut bits at or above bitCount read 0.
- R6: When command code 3 runs with msbFirst = 1, dataIn bit bitCount-1 goes out first and then the lower bits in turn. The TDO bit of data period i lands in dataOut bit bitCount-1-i.
- R7: When endShift = 0, a shift issues exactly bitCount TCK periods with TMS 0 throughout. retIdle has no effect in this case.
- R8: When endShift = 1, TMS is 1 on the last data period only, and one more period with TMS 1 follows. If retIdle = 1 as well, a final period with TMS 0 is added.
- R9: TDI is 1 on every TCK period that carries no data bit, and it is 1 once a command has finished.
- R10: TCK stays low for exactly DIV system clocks per period, where DIV is divCfg and a value of 0 counts as 1. TMS and TDI change only while TCK is high, so each period takes 2·DIV+1 clocks. done appears steps·(2·DIV+1) clocks after the clock edge that accepts start.
- R11: A shift with bitCount equal to 0 or greater than 32 makes no TCK edge, keeps busy low, raises done on the clock edge that accepts start, and leaves dataOut unchanged.
- R12: busy is high from the edge that accepts start until done rises. done lasts one clock. A start pulse while busy is ignored. dataOut changes only through shift commands and holds its value between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divCfg | input | DIV_W (8) | Length of each TCK phase in system clocks; 0 is treated as 1 |
| start | input | 1 | Starts the command on the inputs while the engine is idle |
| cmd | input | 2 | 0 reset to idle, 1 to Shift-IR, 2 to Shift-DR, 3 shift bits |
| dataIn | input | MAX_BITS (32) | Word to shift out |
| bitCount | input | CNT_W (6) | Number of bits to shift, 1 to 32 |
| msbFirst | input | 1 | 1 sends the top bit first, 0 sends bit 0 first |
| endShift | input | 1 | Leaves Shift on the last data bit and goes to Update |
| retIdle | input | 1 | After Update, goes on to Run-Test/Idle |
| busy | output | 1 | A command is running |
| done | output | 1 | One-clock pulse when a command ends |
| dataOut | output | MAX_BITS (32) | Captured word, held until the next shift command |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data toward the target |
| tdo | input | 1 | Test data from the target |

## Verification
The bench targets the count edges.
- With a count of 1, the first bit is also the last bit. An engine that mistimed the exit would raise TMS on the wrong period or never.
- With a count of 32, the mask is full width. A wrong mask or top-bit position would corrupt the top bit of the result.
- Counts of 0 and 33 check that an invalid shift is refused without a stray TCK edge.
- A shift with endShift clear and retIdle set shows whether the idle step leaks in when it should not.

The bench also checks the TCK phase lengths for a divide value above 1 and for a divide value of 0. It tries a start pulse during a running command, which a careless handshake would accept, corrupting the TMS sequence. It checks that a non-shift command leaves the previous result in place.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

  typedef enum logic [1:0] {
    CMD_RESET = 2'd0,
    CMD_IR    = 2'd1,
    CMD_DR    = 2'd2,
    CMD_SHIFT = 2'd3
  } jsmCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } jsmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture dataIn, count and order
    logic sample;   // take tdo and move the word by one bit
    logic setPins;  // register new tms/tdi values
    logic pinTms;   // tms value to register
    logic pinData;  // tdi comes from the word, else 1
    logic parkTdi;  // force tdi to 1
    logic tckLow;   // drive tck low
    logic tckHigh;  // drive tck high
  } jsmStrobe_t;

endpackage

// File: rtl/jsm_ctrl.sv
module jsm_ctrl
  import jsm_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = 6,
  parameter int DIV_W    = 8,
  parameter int STEP_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cmd,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             endShift,
  input  logic             retIdle,
  input  logic [DIV_W-1:0] divCfg,
  output jsmStrobe_t       strobe,
  output logic             busy,
  output logic             done
);

  jsmState_t        state;
  jsmCmd_t          cmdReg;
  logic [CNT_W-1:0] nReg;
  logic             endReg;
  logic             idleReg;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] phase;
  logic [STEP_W-1:0] stepIdx;
  logic             doneReg;

  function automatic logic stepTms(jsmCmd_t c, int idx, int n, logic e);
    case (c)
      CMD_RESET: return idx < 5;
      CMD_IR:    return idx < 2;
      CMD_DR:    return idx == 0;
      default: begin
        if (idx < n) return e && (idx == n - 1);
        return idx == n;   // update step high, idle step low
      end
    endcase
  endfunction

  function automatic logic stepData(jsmCmd_t c, int idx, int n);
    return (c == CMD_SHIFT) && (idx < n);
  endfunction

  function automatic int lastOf(jsmCmd_t c, int n, logic e, logic r);
    case (c)
      CMD_RESET: return 5;
      CMD_IR:    return 3;
      CMD_DR:    return 2;
      default:   return n - 1 + (e ? (r ? 2 : 1) : 0);
    endcase
  endfunction

  logic    isIdle;
  jsmCmd_t effCmd;
  int      effN;
  logic    countOk;
  logic    rejectNow;
  logic    phaseEnd;
  logic    lastStep;
  int      nextIdx;

  always_comb begin
    isIdle    = (state == ST_IDLE);
    effCmd    = isIdle ? jsmCmd_t'(cmd) : cmdReg;
    effN      = isIdle ? int'(bitCount) : int'(nReg);
    countOk   = (bitCount != '0) && (int'(bitCount) <= MAX_BITS);
    rejectNow = (jsmCmd_t'(cmd) == CMD_SHIFT) && !countOk;
    phaseEnd  = (phase == divReg - DIV_W'(1));
    lastStep  = (int'(stepIdx) == lastOf(cmdReg, int'(nReg), endReg, idleReg));
    nextIdx   = isIdle ? 0 : int'(stepIdx) + 1;
  end

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: begin
        if (start && !rejectNow) begin
          strobe.load    = (effCmd == CMD_SHIFT);
          strobe.setPins = 1'b1;
          strobe.pinTms  = stepTms(effCmd, 0, effN, endShift);
          strobe.pinData = stepData(effCmd, 0, effN);
        end
      end
      ST_SETUP: strobe.tckLow = 1'b1;
      ST_LOW:   strobe.tckHigh = phaseEnd;
      ST_HIGH: begin
        if (phaseEnd) begin
          strobe.sample = stepData(cmdReg, int'(stepIdx), effN);
          if (lastStep) begin
            strobe.parkTdi = 1'b1;
          end else begin
            strobe.setPins = 1'b1;
            strobe.pinTms  = stepTms(cmdReg, nextIdx, effN, endReg);
            strobe.pinData = stepData(cmdReg, nextIdx, effN);
          end
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmdReg  <= CMD_RESET;
      nReg    <= '0;
      endReg  <= 1'b0;
      idleReg <= 1'b0;
      divReg  <= DIV_W'(1);
      phase   <= '0;
      stepIdx <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (rejectNow) begin
              doneReg <= 1'b1;
            end else begin
              state   <= ST_SETUP;
              cmdReg  <= jsmCmd_t'(cmd);
              nReg    <= bitCount;
              endReg  <= endShift;
              idleReg <= retIdle;
              divReg  <= (divCfg == '0) ? DIV_W'(1) : divCfg;
              stepIdx <= '0;
            end
          end
        end
        ST_SETUP: begin
          state <= ST_LOW;
          phase <= '0;
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state <= ST_HIGH;
            phase <= '0;
          end else begin
            phase <= phase + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            phase <= '0;
            if (lastStep) begin
              state   <= ST_IDLE;
              doneReg <= 1'b1;
            end else begin
              state   <= ST_SETUP;
              stepIdx <= stepIdx + STEP_W'(1);
            end
          end else begin
            phase <= phase + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = !isIdle;
  assign done = doneReg;

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW || state == ST_HIGH) |-> (phase < divReg)); // R10
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |-> (state == ST_IDLE)); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneReg && !start) |=> !doneReg); // R12

endmodule

// File: rtl/jsm_datapath.sv
module jsm_datapath
  import jsm_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  jsmStrobe_t          strobe,
  input  logic [MAX_BITS-1:0] dataIn,
  input  logic [CNT_W-1:0]    bitCount,
  input  logic                msbFirst,
  input  logic                tdo,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  output logic [MAX_BITS-1:0] wordOut
);

  logic [MAX_BITS-1:0] word;
  logic [CNT_W-1:0]    cntReg;
  logic                msbReg;

  logic [CNT_W-1:0]    effCnt;
  logic                effMsb;
  logic [MAX_BITS-1:0] maskVec;
  logic [MAX_BITS-1:0] topBit;
  logic [MAX_BITS-1:0] shifted;
  logic [MAX_BITS-1:0] wordNext;
  logic                driveBit;

  always_comb begin
    effCnt = strobe.load ? bitCount : cntReg;
    effMsb = strobe.load ? msbFirst : msbReg;
    for (int i = 0; i < MAX_BITS; i++) begin
      maskVec[i] = (i < int'(effCnt));
      topBit[i]  = (i == int'(effCnt) - 1);
    end
    if (effMsb)
      shifted = ((word << 1) & maskVec) | {{(MAX_BITS-1){1'b0}}, tdo};
    else
      shifted = (word >> 1) | (topBit & {MAX_BITS{tdo}});
    if (strobe.load)
      wordNext = dataIn & maskVec;
    else if (strobe.sample)
      wordNext = shifted;
    else
      wordNext = word;
    driveBit = effMsb ? |(wordNext & topBit) : wordNext[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word   <= '0;
      cntReg <= '0;
      msbReg <= 1'b0;
    end else begin
      word <= wordNext;
      if (strobe.load) begin
        cntReg <= bitCount;
        msbReg <= msbFirst;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tck <= 1'b1;
      tms <= 1'b1;
      tdi <= 1'b1;
    end else begin
      if (strobe.tckLow)  tck <= 1'b0;
      if (strobe.tckHigh) tck <= 1'b1;
      if (strobe.setPins) begin
        tms <= strobe.pinTms;
        tdi <= strobe.pinData ? driveBit : 1'b1;
      end else if (strobe.parkTdi) begin
        tdi <= 1'b1;
      end
    end
  end

  assign wordOut = word;

  AST_PINS_FROZEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!tck && !$past(tck)) |-> ($stable(tms) && $stable(tdi))); // R10
  AST_PINS_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tck) |-> ($stable(tms) && $stable(tdi))); // R10

endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master
  import jsm_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int DIV_W    = 8,
  localparam int CNT_W   = $clog2(MAX_BITS + 1),
  localparam int STEP_W  = $clog2(MAX_BITS + 3)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DIV_W-1:0]    divCfg,
  input  logic                start,
  input  logic [1:0]          cmd,
  input  logic [MAX_BITS-1:0] dataIn,
  input  logic [CNT_W-1:0]    bitCount,
  input  logic                msbFirst,
  input  logic                endShift,
  input  logic                retIdle,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] dataOut,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  input  logic                tdo
);

  jsmStrobe_t strobe;

  jsm_ctrl #(
    .MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .DIV_W(DIV_W), .STEP_W(STEP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd),
    .bitCount(bitCount), .endShift(endShift), .retIdle(retIdle),
    .divCfg(divCfg), .strobe(strobe), .busy(busy), .done(done)
  );

  jsm_datapath #(
    .MAX_BITS(MAX_BITS), .CNT_W(CNT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .bitCount(bitCount), .msbFirst(msbFirst), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .wordOut(dataOut)
  );

  AST_TCK_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> tck); // R11
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && cmd == 2'd3 && bitCount == '0) |=> (done && !busy && tck)); // R11

endmodule

// File: tb/jtag_shift_master_tb.sv
module jtag_shift_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_BITS   = 32;
  localparam int DIV_W      = 8;
  localparam int CNT_W      = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] divCfg = '0;
  logic start = 1'b0;
  logic [1:0] cmd = '0;
  logic [MAX_BITS-1:0] dataIn = '0;
  logic [CNT_W-1:0] bitCount = '0;
  logic msbFirst = 1'b0, endShift = 1'b0, retIdle = 1'b0;
  logic busy, done, tck, tms, tdi;
  logic tdo = 1'b0;
  logic [MAX_BITS-1:0] dataOut;

  jtag_shift_master #(.MAX_BITS(MAX_BITS), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN), .divCfg(divCfg), .start(start), .cmd(cmd),
    .dataIn(dataIn), .bitCount(bitCount), .msbFirst(msbFirst),
    .endShift(endShift), .retIdle(retIdle), .busy(busy), .done(done),
    .dataOut(dataOut), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic recTms [0:63];
  logic recTdi [0:63];
  int nRise = 0;
  int nFall = 0;
  logic [63:0] pattern = 64'h0;
  int expDiv = 1;
  int lowLen = 0;
  int lowLenBad = 0;
  int pinViolations = 0;
  logic pTck = 1'b1, pTms = 1'b1, pTdi = 1'b1;
  int lat = 0;
  logic busySeen = 1'b0;

  // target side: record pins on rising TCK, drive TDO on falling TCK
  always @(posedge tck) begin
    if (nRise < 64) begin
      recTms[nRise] = tms;
      recTdi[nRise] = tdi;
    end
    nRise = nRise + 1;
  end

  always @(negedge tck) begin
    tdo <= pattern[nFall & 63];
    nFall = nFall + 1;
  end

  // pin timing monitor (R10)
  always @(negedge clk) begin
    if (rstN) begin
      if (!tck && (tms !== pTms || tdi !== pTdi)) pinViolations++;
      if (!tck) lowLen++;
      else if (!pTck) begin
        if (lowLen != expDiv) lowLenBad++;
        lowLen = 0;
      end
    end
    pTck = tck; pTms = tms; pTdi = tdi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runCmd(input logic [1:0] c, input logic [31:0] d, input int n,
                        input bit msb, input bit e, input bit r, input int div);
    @(negedge clk);
    nRise = 0; nFall = 0; lowLen = 0;
    expDiv = (div == 0) ? 1 : div;
    cmd = c; dataIn = d; bitCount = n[CNT_W-1:0];
    msbFirst = msb; endShift = e; retIdle = r; divCfg = div[DIV_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dataIn = ~d;          // later changes must not matter
    bitCount = 6'd7; msbFirst = ~msb; endShift = ~e; retIdle = ~r;
    lat = 1;
    busySeen = busy;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic checkTms(input string req, input logic [63:0] expSeq, input int steps);
    logic [63:0] got = '0;
    for (int i = 0; i < steps; i++) got[i] = recTms[i];
    chk(nRise == steps, req, "tck rising edges", 64'(nRise), 64'(steps));
    chk(got == expSeq, req, "tms sequence", got, expSeq);
  endtask

  task automatic checkShift(input string req, input logic [31:0] d, input int n,
                            input bit msb, input bit e, input bit r, input int div);
    int steps;
    int dv;
    logic [63:0] expTms = '0, expTdi = '0, gotTdi = '0;
    logic [31:0] expOut = '0;
    pattern = {d ^ 32'h6b3c_91e5, ~d};
    runCmd(2'd3, d, n, msb, e, r, div);
    steps = n + (e ? (r ? 2 : 1) : 0);
    dv = (div == 0) ? 1 : div;
    for (int i = 0; i < steps; i++) begin
      if (i < n) begin
        expTms[i] = e && (i == n - 1);
        expTdi[i] = msb ? d[n-1-i] : d[i];
        if (msb) expOut[n-1-i] = pattern[i];
        else     expOut[i] = pattern[i];
      end else begin
        expTms[i] = (i == n);
        expTdi[i] = 1'b1;
      end
      gotTdi[i] = recTdi[i];
    end
    checkTms(req, expTms, steps);
    chk(gotTdi == expTdi, req, "tdi sequence", gotTdi, expTdi);
    chk(dataOut == expOut, req, "captured word", 64'(dataOut), 64'(expOut));
    chk(lat == steps * (2 * dv + 1) + 1, "R10", "command latency", 64'(lat),
        64'(steps * (2 * dv + 1) + 1));
    chk(tdi == 1'b1, "R9", "tdi after shift", 64'(tdi), 64'd1);
  endtask

  task automatic t_reset_state;
    chk(tck == 1 && tms == 1 && tdi == 1, "R1", "pins after reset",
        {61'd0, tck, tms, tdi}, 64'd7);
    chk(busy == 0 && done == 0, "R1", "busy/done after reset", {62'd0, busy, done}, 64'd0);
    chk(dataOut == '0, "R1", "dataOut after reset", 64'(dataOut), 64'd0);
  endtask

  task automatic t_nav;
    logic [63:0] allOnes;
    runCmd(2'd0, 32'h0, 0, 0, 0, 0, 1);
    checkTms("R2", 64'b011111, 6);
    allOnes = '0;
    for (int i = 0; i < 6; i++) allOnes[i] = recTdi[i];
    chk(allOnes == 64'h3f, "R9", "tdi during reset walk", allOnes, 64'h3f);
    chk(lat == 6 * 3 + 1, "R10", "reset walk latency", 64'(lat), 64'd19);
    runCmd(2'd1, 32'h0, 0, 0, 0, 0, 1);
    checkTms("R3", 64'b0011, 4);
    runCmd(2'd2, 32'h0, 0, 0, 0, 0, 1);
    checkTms("R4", 64'b001, 3);
  endtask

  task automatic t_shifts;
    checkShift("R5", 32'h0000_00a5, 8, 0, 1, 1, 1);        // R8 exit + idle
    checkShift("R6", 32'h0000_1ace, 13, 1, 1, 0, 1);       // R8 exit, stop at update
    checkShift("R7", 32'h0000_0013, 5, 0, 0, 1, 1);        // retIdle ignored
    checkShift("R5", 32'hdead_beef, 32, 0, 1, 1, 1);
    checkShift("R6", 32'h8123_4567, 32, 1, 1, 1, 1);
    checkShift("R8", 32'h0000_0001, 1, 1, 1, 1, 1);        // single bit exits
    checkShift("R5", 32'hffff_fff5, 4, 0, 0, 0, 1);        // upper bits ignored
  endtask

  task automatic t_reject;
    logic [31:0] prev;
    prev = dataOut;
    runCmd(2'd3, 32'h1234_5678, 0, 0, 1, 1, 1);
    chk(nRise == 0, "R11", "tck edges for count 0", 64'(nRise), 64'd0);
    chk(lat == 1 && busySeen == 0, "R11", "done latency for count 0", 64'(lat), 64'd1);
    chk(dataOut == prev, "R11", "dataOut kept for count 0", 64'(dataOut), 64'(prev));
    runCmd(2'd3, 32'h1234_5678, 33, 0, 1, 1, 1);
    chk(nRise == 0 && lat == 1, "R11", "count 33 refused", 64'(nRise), 64'd0);
    chk(dataOut == prev, "R11", "dataOut kept for count 33", 64'(dataOut), 64'(prev));
  endtask

  task automatic t_div;
    int badBefore;
    badBefore = lowLenBad;
    checkShift("R10", 32'h0000_0b6d, 12, 1, 1, 1, 3);
    chk(lowLenBad == badBefore, "R10", "tck low length div 3", 64'(lowLenBad), 64'(badBefore));
    checkShift("R10", 32'h0000_0036, 6, 0, 1, 0, 0);
    chk(lowLenBad == badBefore, "R10", "tck low length div 0", 64'(lowLenBad), 64'(badBefore));
  endtask

  task automatic t_handshake;
    logic [31:0] prev;
    int cyc;
    prev = dataOut;
    @(negedge clk);
    nRise = 0; nFall = 0; expDiv = 2;
    cmd = 2'd2; divCfg = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1, "R12", "busy after start", 64'(busy), 64'd1);
    repeat (3) @(negedge clk);
    cmd = 2'd0; start = 1'b1;          // must be ignored
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(busy == 0, "R12", "busy low with done", 64'(busy), 64'd0);
    checkTms("R12", 64'b001, 3);
    @(negedge clk);
    chk(done == 0, "R12", "done one clock", 64'(done), 64'd0);
    chk(dataOut == prev, "R12", "dataOut held over non-shift", 64'(dataOut), 64'(prev));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_nav();
    t_shifts();
    t_reject();
    t_div();
    t_handshake();
    chk(pinViolations == 0, "R10", "pins changed while tck low", 64'(pinViolations), 64'd0);
    chk(lowLenBad == 0, "R10", "tck low phase length", 64'(lowLenBad), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule